// File: doc/BRIEF.md
# Four-Channel Compare Timer

The block is a timer for an operating system. One free-running up-counter advances on every cycle in which the `tick` strobe is high. Four compare registers each watch that counter. When the count equals a compare value on a tick, the channel's sticky hit flag is set. Each flag can be routed to its own interrupt line through a per-channel enable bit.

Software reaches every register through a word-wide register bus with single-cycle writes and registered reads. Because the counter is writable, a suspend/resume sequence can save the count and put it back later. The last channel can also serve as a watchdog. Once software arms that function, a match on that channel emits a one-cycle reset request. Software cannot disarm it again; only a reset does that.

Register word offsets (byte address): compare 0..3 at 0x00/0x04/0x08/0x0C, counter at 0x10, hit flags at 0x14, watchdog arm at 0x18, interrupt enables at 0x1C. Any byte address at or above 0x20 is unmapped.

Top module: `match_timer`

## Requirements
- R1: After a synchronous reset, every register holds its reset value. The counter is 0, the hit flags are 0, the interrupt enables are 0, the watchdog arm bit is 0 and all compare registers are 0xFFFFFFFF. The `irq` outputs and `wdog_rst_req` are low.
- R2: The counter goes up by one at each clock edge where `tick` is high. It holds its value when `tick` is low, and it wraps from 0xFFFFFFFF to 0.
- R3: A write to byte offset 0x10 loads the counter. In the same cycle the load takes precedence over a tick.
- R4: Compare registers 0 to 3 sit at byte offsets 0x00, 0x04, 0x08 and 0x0C. Each can be written and read back at any time, and a write to one leaves the others untouched.
- R5: The hit flag of channel n is set at the clock edge where `tick` is high and the counter equals compare register n. Flags are read at offset 0x14, with bit n belonging to channel n.
- R6: Writing 1 to bit n of offset 0x14 clears flag n, and writing 0 leaves it unchanged. If a hit and a clear of the same flag happen in one cycle, the flag ends up set.
- R7: `irq[n]` is a registered copy of (flag n AND enable bit n). The enable bits are at offset 0x1C, bit n for channel n. `irq[n]` follows one cycle after the flag or the enable changes. Clearing an enable bit does not alter any compare register.
- R8: Writing 1 to bit 0 of offset 0x18 arms the watchdog, and the arm bit then stays 1 until reset. While armed, a channel 3 hit drives `wdog_rst_req` high for exactly the next cycle. While disarmed, a channel 3 hit produces no request.
- R9: A read returns its data on `bus_rdata` in the cycle after `bus_rd`. Unused bits of the flag, enable and arm registers read as 0. Unmapped offsets read 0, and writes to them change no register.
- R10: A compare value the counter has already passed is not flagged until the counter wraps around and reaches it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count strobe, one increment per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 4 | Per-channel interrupt levels |
| wdog_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest situation to reach is a hit and a software clear of the same flag in one cycle. To produce it, the bench loads the counter and a compare register with the same value, then raises `tick` in the very cycle it writes the clear. Equality at the 32-bit wrap is the other hard case. The bench reaches it by writing the counter to just below 0xFFFFFFFF instead of counting there, which also lets it confirm that a compare value below the start count is flagged only after the wrap. A behavioural model follows every bus access and tick, and the outputs are compared with it on every clock.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;

  typedef enum logic [2:0] {
    RK_MATCH,
    RK_COUNT,
    RK_STATUS,
    RK_WDOG,
    RK_IEN,
    RK_NONE
  } reg_kind_e;

  // Word layout: compare registers first, then counter, flags, arm, enables.
  function automatic reg_kind_e decode_word(input int unsigned word,
                                            input int unsigned nch);
    if (word < nch)           return RK_MATCH;
    else if (word == nch)     return RK_COUNT;
    else if (word == nch + 1) return RK_STATUS;
    else if (word == nch + 2) return RK_WDOG;
    else if (word == nch + 3) return RK_IEN;
    else                      return RK_NONE;
  endfunction

endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= count + 1'b1;
  end

endmodule

// File: rtl/mt_channel.sv
module mt_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         wr_match,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  output logic [W-1:0] match_q,
  output logic         hit,
  output logic         flag_q
);

  assign hit = tick && (count == match_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '1;
      flag_q  <= 1'b0;
    end else begin
      if (wr_match) match_q <= wdata;
      flag_q <= (flag_q & ~clr) | hit;
    end
  end

endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int NCH     = 4,
  parameter int ADDR_W  = 6,
  parameter int WDOG_CH = NCH - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    irq,
  output logic              wdog_rst_req
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]           word;
  reg_kind_e                   kind;
  logic                        cnt_wr;
  logic [NCH-1:0]              match_wr;
  logic [NCH-1:0]              clr;
  logic [NCH-1:0]              hits;
  logic [NCH-1:0]              flags;
  logic [NCH-1:0]              ien_q;
  logic                        wdog_q;
  logic [CNT_W-1:0]            count_q;
  logic [NCH-1:0][CNT_W-1:0]   match_q;
  logic [CNT_W-1:0]            rd_mux;

  assign word   = bus_addr[ADDR_W-1:2];
  assign kind   = decode_word(int'(word), NCH);
  assign cnt_wr = bus_wr && (kind == RK_COUNT);
  assign clr    = (bus_wr && (kind == RK_STATUS)) ? bus_wdata[NCH-1:0] : '0;

  mt_counter #(.W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (cnt_wr),
    .load_val (bus_wdata),
    .count    (count_q)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign match_wr[n] = bus_wr && (kind == RK_MATCH) && (int'(word) == n);

    mt_channel #(.W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .count    (count_q),
      .wr_match (match_wr[n]),
      .wdata    (bus_wdata),
      .clr      (clr[n]),
      .match_q  (match_q[n]),
      .hit      (hits[n]),
      .flag_q   (flags[n])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (kind)
      RK_MATCH: begin
        for (int n = 0; n < NCH; n++)
          if (int'(word) == n) rd_mux = match_q[n];
      end
      RK_COUNT:  rd_mux = count_q;
      RK_STATUS: rd_mux[NCH-1:0] = flags;
      RK_WDOG:   rd_mux[0] = wdog_q;
      RK_IEN:    rd_mux[NCH-1:0] = ien_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q        <= '0;
      wdog_q       <= 1'b0;
      irq          <= '0;
      wdog_rst_req <= 1'b0;
      bus_rdata    <= '0;
    end else begin
      if (bus_wr && kind == RK_IEN) ien_q <= bus_wdata[NCH-1:0];
      if (bus_wr && kind == RK_WDOG && bus_wdata[0]) wdog_q <= 1'b1;
      irq          <= flags & ien_q;
      wdog_rst_req <= wdog_q & hits[WDOG_CH];
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int CNT_W = 32,
  parameter int NCH   = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      tick,
  input logic                      cnt_wr,
  input logic [CNT_W-1:0]          bus_wdata,
  input logic [CNT_W-1:0]          count_q,
  input logic [NCH-1:0]            match_wr,
  input logic [NCH-1:0][CNT_W-1:0] match_q,
  input logic [NCH-1:0]            hits,
  input logic [NCH-1:0]            flags,
  input logic [NCH-1:0]            ien_q,
  input logic                      wdog_q,
  input logic [NCH-1:0]            irq,
  input logic                      wdog_rst_req
);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr) |=> (count_q == $past(count_q) + 1'b1)); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(count_q)); // R2
  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (count_q == $past(bus_wdata))); // R3
  AST_MATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
    (match_wr == '0) |=> $stable(match_q)); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (hits != '0) |=> ((flags & $past(hits)) == $past(hits))); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    ((irq & ~$past(ien_q)) == '0)); // R7
  AST_WDOG_STICKY: assert property (@(posedge clk) disable iff (rst)
    wdog_q |=> wdog_q); // R8
  AST_RREQ_ARMED: assert property (@(posedge clk) disable iff (rst)
    wdog_rst_req |-> wdog_q); // R8

endmodule

bind match_timer match_timer_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tick         (tick),
  .cnt_wr       (cnt_wr),
  .bus_wdata    (bus_wdata),
  .count_q      (count_q),
  .match_wr     (match_wr),
  .match_q      (match_q),
  .hits         (hits),
  .flags        (flags),
  .ien_q        (ien_q),
  .wdog_q       (wdog_q),
  .irq          (irq),
  .wdog_rst_req (wdog_rst_req)
);

// File: tb/test_match_timer.sv
module test_match_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  logic        wdog_rst_req;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  match_timer i_match_timer (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq          (irq),
    .wdog_rst_req (wdog_rst_req)
  );

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // Behavioural reference model, stepped on every rising edge.
  logic [31:0] m_cnt;
  logic [31:0] m_match [4];
  logic [3:0]  m_flag, m_en, m_irq;
  logic        m_wdt, m_rreq;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    logic [3:0]  h;
    logic [3:0]  c;
    logic [31:0] r;
    int          w;
    if (rst) begin
      m_cnt = 0; m_flag = 0; m_en = 0; m_irq = 0; m_wdt = 0; m_rreq = 0; m_rdata = 0;
      for (int n = 0; n < 4; n++) m_match[n] = 32'hFFFF_FFFF;
    end else begin
      w = int'(bus_addr[5:2]);
      h = 0;
      for (int n = 0; n < 4; n++) if (tick && m_cnt == m_match[n]) h[n] = 1'b1;
      r = 0;
      if (w < 4) r = m_match[w];
      else if (w == 4) r = m_cnt;
      else if (w == 5) r = {28'b0, m_flag};
      else if (w == 6) r = {31'b0, m_wdt};
      else if (w == 7) r = {28'b0, m_en};
      if (bus_rd) m_rdata = r;
      m_irq  = m_flag & m_en;
      m_rreq = m_wdt & h[3];
      c = (bus_wr && w == 5) ? bus_wdata[3:0] : 4'b0;
      m_flag = (m_flag & ~c) | h;
      if (bus_wr && w == 4) m_cnt = bus_wdata;
      else if (tick) m_cnt = m_cnt + 1;
      if (bus_wr && w < 4) m_match[w] = bus_wdata;
      if (bus_wr && w == 7) m_en = bus_wdata[3:0];
      if (bus_wr && w == 6 && bus_wdata[0]) m_wdt = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R7 irq vs model", {28'b0, irq}, {28'b0, m_irq});
      chk("R8 wdog_rst_req vs model", {31'b0, wdog_rst_req}, {31'b0, m_rreq});
      chk("R9 bus_rdata vs model", bus_rdata, m_rdata);
      if (wdog_rst_req) pulses++;
    end
  end

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic run_ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    bus_read(6'h00, 32'hFFFF_FFFF, "R1 compare0 reset");
    bus_read(6'h0C, 32'hFFFF_FFFF, "R1 compare3 reset");
    bus_read(6'h10, 32'h0, "R1 counter reset");
    bus_read(6'h14, 32'h0, "R1 flags reset");
    bus_read(6'h18, 32'h0, "R1 arm reset");
    bus_read(6'h1C, 32'h0, "R1 enables reset");
    chk("R1 irq reset", {28'b0, irq}, 32'h0);
    chk("R1 reset request idle", {31'b0, wdog_rst_req}, 32'h0);

    // R2 counting, hold and wrap
    run_ticks(10);
    bus_read(6'h10, 32'd10, "R2 count after 10 ticks");
    bus_write(6'h10, 32'hFFFF_FFFE);
    run_ticks(3);
    bus_read(6'h10, 32'd1, "R2 wrap to 1");
    bus_read(6'h14, 32'hF, "R5 all-ones compare hit at wrap");
    bus_write(6'h14, 32'hF);
    bus_read(6'h14, 32'h0, "R6 clear all flags");

    // R3 load beats tick
    tick = 1'b1;
    bus_write(6'h10, 32'd100);
    tick = 1'b0;
    bus_read(6'h10, 32'd100, "R3 load wins over tick");

    // R4 compare registers
    bus_write(6'h04, 32'h1234_5678);
    bus_read(6'h04, 32'h1234_5678, "R4 compare1 readback");
    bus_read(6'h08, 32'hFFFF_FFFF, "R4 compare2 untouched");

    // R5 / R7 hit and gating
    bus_write(6'h10, 32'd0);
    bus_write(6'h00, 32'd5);
    bus_write(6'h04, 32'd7);
    bus_write(6'h1C, 32'h1);
    run_ticks(10);
    bus_read(6'h14, 32'h3, "R5 flags for channels 0 and 1");
    chk("R7 only enabled channel raises irq", {28'b0, irq}, 32'h1);

    // R6 write-one-to-clear and set priority
    bus_write(6'h14, 32'h0);
    bus_read(6'h14, 32'h3, "R6 zero write keeps flags");
    bus_write(6'h14, 32'h1);
    bus_read(6'h14, 32'h2, "R6 one clears flag 0");
    chk("R7 irq drops with flag", {28'b0, irq}, 32'h0);
    bus_write(6'h14, 32'hF);
    bus_write(6'h10, 32'd50);
    bus_write(6'h08, 32'd50);
    tick = 1'b1;
    bus_write(6'h14, 32'h4);
    tick = 1'b0;
    bus_read(6'h14, 32'h4, "R6 set wins over clear");

    // R7 enable and disarm
    bus_write(6'h1C, 32'h4);
    @(negedge clk);
    chk("R7 irq2 after enable", {28'b0, irq}, 32'h4);
    bus_write(6'h1C, 32'h0);
    bus_read(6'h08, 32'd50, "R7 disarm keeps compare2");
    chk("R7 irq off after disarm", {28'b0, irq}, 32'h0);

    // R8 watchdog request
    bus_write(6'h14, 32'hF);
    bus_write(6'h10, 32'd200);
    bus_write(6'h0C, 32'd202);
    pulses = 0;
    run_ticks(5);
    @(negedge clk);
    chk("R8 no request while disarmed", pulses, 0);
    bus_read(6'h14, 32'h8, "R5 channel 3 flag");
    bus_write(6'h18, 32'h1);
    bus_write(6'h10, 32'd300);
    bus_write(6'h0C, 32'd303);
    run_ticks(6);
    @(negedge clk);
    chk("R8 exactly one request pulse", pulses, 1);
    bus_write(6'h18, 32'h0);
    bus_read(6'h18, 32'h1, "R8 arm bit sticky");

    // R9 unused bits and unmapped offsets
    bus_write(6'h1C, 32'hFFFF_FFFF);
    bus_read(6'h1C, 32'hF, "R9 enable upper bits zero");
    bus_write(6'h20, 32'hAAAA_AAAA);
    bus_write(6'h30, 32'h5555_5555);
    bus_read(6'h20, 32'h0, "R9 unmapped reads zero");
    bus_read(6'h10, 32'd306, "R9 counter untouched by unmapped write");
    bus_read(6'h00, 32'd5, "R9 compare0 untouched by unmapped write");

    // R10 passed compare waits for the wrap
    bus_write(6'h14, 32'hF);
    bus_write(6'h10, 32'd100);
    bus_write(6'h04, 32'd50);
    run_ticks(100);
    bus_read(6'h14, 32'h0, "R10 passed value not flagged");
    bus_write(6'h10, 32'hFFFF_FFF0);
    run_ticks(80);
    bus_read(6'h14, 32'h7, "R10 flagged after wrap");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule